// File: doc/BRIEF.md
# Hit Channel Readout Sequencer

This block sits between the per-strip comparators of a 128-channel detector front end and the on-chip converter and data buffer. Each strip supplies two comparator levels: a fast timing comparator and a slow energy-threshold comparator. When the timing comparator fires, the block stores the current value of a free-running timestamp counter for that strip. When the threshold comparator fires, the strip is marked as hit and is scheduled for readout together with its two adjacent strips. The block also drives a chip-wide trigger, which is the OR of all hit marks.

The sequencer serves scheduled strips one at a time, always taking the lowest pending address. For each strip it sets the analogue multiplexer select, pulses the converter start and waits for the converter's done strobe. It then emits one data word for the downstream buffer and pulses that strip's reset for one cycle. The reset clears the strip's hit mark, pending mark and timestamp so the strip is ready for the next event.

Output word layout (35 bits with default parameters): bit 34 is the timestamp-valid flag, bits 33:19 are the timestamp, bits 18:12 are the channel address and bits 11:0 are the converted sample.

Top module: `hit_readout_seq`

## Requirements
- R1: A strip whose threshold input is high in a cycle is scheduled and produces exactly one output word. Scheduled strips are emitted in ascending address order, and the address sits in word bits 18:12.
- R2: A hit on strip i also schedules strips i-1 and i+1. At strip 0 and strip 127 the missing neighbour is simply absent: there is no wrap-around.
- R3: The timestamp counter starts at 0 when reset is released and increments once per cycle. Word bits 33:19 hold the counter value seen at the clock edge where the strip's timing input was first high.
- R4: Word bit 34 is 1 only if the strip's timing input fired. For a strip read only as a neighbour, or whose timing input never fired, bit 34 is 0 and bits 33:19 are 0.
- R5: A new threshold or timing pulse on a strip that is already pending adds no second word, and the first latched timestamp is kept.
- R6: For each strip, `adc_start` is a one-cycle pulse issued while `mux_sel` equals that strip's address. `mux_sel` holds that value until `adc_done`, and word bits 11:0 equal `adc_data` in the `adc_done` cycle.
- R7: In the cycle after `adc_done`, `word_valid` and the one-hot `ch_rst` bit of the converted strip are high for exactly one cycle. No `ch_rst` bit is high at any other time.
- R8: `trig_or` goes high in the cycle after any threshold input is high. It stays high until every hit strip has received its reset.
- R9: While reset is asserted, `trig_or`, `adc_start`, `word_valid`, `ch_rst` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_cmp | input | 128 | Timing comparator level per strip |
| thr_cmp | input | 128 | Energy-threshold comparator level per strip |
| adc_done | input | 1 | Converter done strobe |
| adc_data | input | 12 | Converted sample, valid with adc_done |
| trig_or | output | 1 | OR of all hit marks |
| mux_sel | output | 7 | Analogue multiplexer select |
| adc_start | output | 1 | Converter start pulse |
| ch_rst | output | 128 | Per-strip reset pulse |
| word_valid | output | 1 | Output word strobe |
| word_data | output | 35 | {ts_valid, timestamp, address, sample} |

## Verification
Comparator inputs are captured at the next clock edge. As a result, `trig_or` is due one cycle after a threshold pulse, and a stored timestamp equals the counter value seen in the cycle the timing pulse was driven. The bench reproduces that value by counting clock edges since reset release. A word and its strip reset are due exactly one cycle after the edge that samples `adc_done`.

The bench drives every input on the falling edge and samples every output on the falling edge. The ADC model reads `mux_sel` when it sees `adc_start`, and checks that value again when it raises done. Expected words are queued in ascending address order when the threshold pulse is applied and are compared as they appear. After each batch, a quiet interval confirms that no extra word arrives and that `trig_or` has dropped.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_CONV = 2'd1,
        RS_CLR  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/hrs_tstamp_ctr.sv
module hrs_tstamp_ctr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/hrs_chan_bank.sv
module hrs_chan_bank #(
    parameter int NCH = 128,
    parameter int TSW = 15,
    parameter int AW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fast_cmp,
    input  logic [NCH-1:0] thr_cmp,
    input  logic [TSW-1:0] ts_now,
    input  logic [NCH-1:0] clr,
    input  logic [AW-1:0]  rd_sel,
    output logic [NCH-1:0] pend,
    output logic [NCH-1:0] hit,
    output logic [TSW-1:0] rd_ts,
    output logic           rd_tsv
);
    logic [TSW-1:0] ts_arr  [NCH];
    logic           tsv_arr [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        typedef struct packed {
            logic           hit;
            logic           pend;
            logic           tsv;
            logic [TSW-1:0] ts;
        } ch_t;

        ch_t  ch_d, ch_q;
        logic near;

        // Neighbour pull-in, no wrap at the array ends
        if (i == 0) begin : g_lo
            assign near = thr_cmp[i] | thr_cmp[i+1];
        end else if (i == NCH-1) begin : g_hi
            assign near = thr_cmp[i] | thr_cmp[i-1];
        end else begin : g_mid
            assign near = thr_cmp[i] | thr_cmp[i-1] | thr_cmp[i+1];
        end

        always_comb begin
            ch_d      = ch_q;
            ch_d.hit  = (ch_q.hit  & ~clr[i]) | thr_cmp[i];
            ch_d.pend = (ch_q.pend & ~clr[i]) | near;
            if (clr[i]) begin
                ch_d.tsv = 1'b0;
                ch_d.ts  = '0;
            end
            if (fast_cmp[i] && (!ch_q.tsv || clr[i])) begin
                ch_d.tsv = 1'b1;
                ch_d.ts  = ts_now;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= ch_d;
        end

        assign pend[i]    = ch_q.pend;
        assign hit[i]     = ch_q.hit;
        assign ts_arr[i]  = ch_q.ts;
        assign tsv_arr[i] = ch_q.tsv;
    end

    assign rd_ts  = ts_arr[rd_sel];
    assign rd_tsv = tsv_arr[rd_sel];
endmodule

// File: rtl/hrs_low_pick.sv
module hrs_low_pick #(
    parameter int N  = 128,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (vec[i]) idx = i[AW-1:0];
        end
        found = |vec;
    end
endmodule

// File: rtl/hit_readout_seq.sv
module hit_readout_seq #(
    parameter int NCH = 128,
    parameter int TSW = 15,
    parameter int ADW = 12,
    localparam int AW = $clog2(NCH),
    localparam int WW = 1 + TSW + AW + ADW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fast_cmp,
    input  logic [NCH-1:0] thr_cmp,
    input  logic           adc_done,
    input  logic [ADW-1:0] adc_data,
    output logic           trig_or,
    output logic [AW-1:0]  mux_sel,
    output logic           adc_start,
    output logic [NCH-1:0] ch_rst,
    output logic           word_valid,
    output logic [WW-1:0]  word_data
);
    import hrs_pkg::*;

    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] sel;
        logic          start;
        logic          wvalid;
        logic [WW-1:0] wdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [TSW-1:0] ts_now;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] hit;
    logic [TSW-1:0] rd_ts;
    logic           rd_tsv;
    logic           any_pend;
    logic [AW-1:0]  low_idx;

    hrs_tstamp_ctr #(.W(TSW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (ts_now)
    );

    hrs_chan_bank #(.NCH(NCH), .TSW(TSW), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_cmp (fast_cmp),
        .thr_cmp  (thr_cmp),
        .ts_now   (ts_now),
        .clr      (ch_rst),
        .rd_sel   (seq_q.sel),
        .pend     (pend),
        .hit      (hit),
        .rd_ts    (rd_ts),
        .rd_tsv   (rd_tsv)
    );

    hrs_low_pick #(.N(NCH), .AW(AW)) u_pick (
        .vec   (pend),
        .found (any_pend),
        .idx   (low_idx)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.start  = 1'b0;
        seq_d.wvalid = 1'b0;
        unique case (seq_q.st)
            RS_IDLE: begin
                if (any_pend) begin
                    seq_d.sel   = low_idx;
                    seq_d.start = 1'b1;
                    seq_d.st    = RS_CONV;
                end
            end
            RS_CONV: begin
                if (adc_done) begin
                    seq_d.wvalid = 1'b1;
                    seq_d.wdata  = {rd_tsv, rd_ts, seq_q.sel, adc_data};
                    seq_d.st     = RS_CLR;
                end
            end
            RS_CLR: begin
                seq_d.st = RS_IDLE;
            end
            default: seq_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= RS_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_rst
        assign ch_rst[i] = seq_q.wvalid && (seq_q.sel == AW'(i));
    end

    assign trig_or    = |hit;
    assign mux_sel    = seq_q.sel;
    assign adc_start  = seq_q.start;
    assign word_valid = seq_q.wvalid;
    assign word_data  = seq_q.wdata;
endmodule

// File: rtl/hit_readout_chk.sv
module hit_readout_chk #(
    parameter int NCH = 128,
    parameter int TSW = 15,
    parameter int ADW = 12,
    localparam int AW = $clog2(NCH),
    localparam int WW = 1 + TSW + AW + ADW
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] thr_cmp,
    input logic           trig_or,
    input logic [AW-1:0]  mux_sel,
    input logic           adc_start,
    input logic [NCH-1:0] ch_rst,
    input logic           word_valid,
    input logic [WW-1:0]  word_data
);
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R6
    addr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_data[ADW +: AW] == mux_sel));

    // R7
    rst_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rst));

    // R7
    rst_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rst != '0) |-> word_valid);

    // R7
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8
    trig_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_cmp != '0) |=> trig_or);

    // R4
    ts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_data[WW-1]) |-> (word_data[ADW+AW +: TSW] == '0));
endmodule

bind hit_readout_seq hit_readout_chk #(.NCH(NCH), .TSW(TSW), .ADW(ADW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_cmp    (thr_cmp),
    .trig_or    (trig_or),
    .mux_sel    (mux_sel),
    .adc_start  (adc_start),
    .ch_rst     (ch_rst),
    .word_valid (word_valid),
    .word_data  (word_data)
);

// File: tb/hit_readout_seq_tb.sv
module hit_readout_seq_tb;
    localparam int NCH = 128;
    localparam int TSW = 15;
    localparam int ADW = 12;
    localparam int AW  = 7;
    localparam int WW  = 1 + TSW + AW + ADW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] fast_cmp = '0;
    logic [NCH-1:0] thr_cmp = '0;
    logic           adc_done = 1'b0;
    logic [ADW-1:0] adc_data = '0;
    logic           trig_or;
    logic [AW-1:0]  mux_sel;
    logic           adc_start;
    logic [NCH-1:0] ch_rst;
    logic           word_valid;
    logic [WW-1:0]  word_data;

    int nchk = 0;
    int nfail = 0;
    logic [TSW-1:0] cyc = '0;
    logic [ADW-1:0] salt = '0;
    logic [WW-1:0]  exp_q[$];
    bit             prev_start = 1'b0;

    always #5 clk = ~clk;

    hit_readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fast_cmp(fast_cmp), .thr_cmp(thr_cmp),
        .adc_done(adc_done), .adc_data(adc_data), .trig_or(trig_or),
        .mux_sel(mux_sel), .adc_start(adc_start), .ch_rst(ch_rst),
        .word_valid(word_valid), .word_data(word_data)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADW-1:0] sample_of(input logic [AW-1:0] a);
        return ({5'b0, a} * 12'd29) ^ salt;
    endfunction

    // ADC model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && adc_start) begin
                logic [AW-1:0] a;
                a = mux_sel;
                repeat (1 + ($urandom % 4)) @(negedge clk);
                chk(mux_sel == a, "R6 mux_sel held until done", 128'(mux_sel), 128'(a));
                adc_data = sample_of(a);
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (adc_start && prev_start)
                    chk(1'b0, "R6 adc_start longer than one cycle", 1, 0);
                prev_start = adc_start;
                if (word_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected extra word", 128'(word_data), 0);
                    end else begin
                        logic [WW-1:0] e;
                        e = exp_q.pop_front();
                        chk(word_data == e, "R1 R2 R3 R4 R6 word content/order", 128'(word_data), 128'(e));
                        chk(ch_rst == (128'(1) << word_data[ADW +: AW]), "R7 channel reset",
                            ch_rst, 128'(1) << word_data[ADW +: AW]);
                    end
                end else if (ch_rst != '0) begin
                    chk(1'b0, "R7 reset without word", ch_rst, 0);
                end
            end
        end
    end

    task automatic run_batch(input logic [NCH-1:0] hits, input logic [NCH-1:0] fasts, input int rehit);
        logic [TSW-1:0] ts[NCH];
        salt = 12'($urandom);
        for (int c = 0; c < NCH; c++) begin
            ts[c] = '0;
            if (fasts[c]) begin
                @(negedge clk);
                fast_cmp = '0;
                fast_cmp[c] = 1'b1;
                ts[c] = cyc;
            end
        end
        @(negedge clk);
        fast_cmp = '0;
        thr_cmp = hits;
        for (int c = 0; c < NCH; c++) begin
            bit sel;
            sel = hits[c] || (c > 0 && hits[c-1]) || (c < NCH-1 && hits[c+1]);
            if (sel) exp_q.push_back({fasts[c], ts[c], AW'(c), sample_of(AW'(c))});
        end
        @(negedge clk);
        thr_cmp = '0;
        chk(trig_or == (hits != '0), "R8 trigger after hit", 128'(trig_or), 128'(hits != '0));
        if (rehit >= 0) begin
            @(negedge clk);
            thr_cmp[rehit] = 1'b1;
            fast_cmp[rehit] = 1'b1;
            @(negedge clk);
            thr_cmp = '0;
            fast_cmp = '0;
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(trig_or == 1'b0, "R8 trigger drops after resets", 128'(trig_or), 0);
        chk(exp_q.size() == 0, "R5 no missing word", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!trig_or && !adc_start && !word_valid && ch_rst == '0 && mux_sel == '0,
            "R9 reset outputs", {trig_or, adc_start, word_valid, mux_sel}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R2 edges without wrap
        run_batch((128'(1) << 0) | (128'(1) << 127), 128'(1) << 127, -1);
        // R2 overlapping neighbours, R4 none timed
        run_batch((128'(1) << 40) | (128'(1) << 42) | (128'(1) << 5) | (128'(1) << 6), '0, -1);
        // R5 re-hit on a pending channel keeps first timestamp
        run_batch((128'(1) << 10) | (128'(1) << 50), (128'(1) << 10) | (128'(1) << 50), 50);
        // R3 spread timestamps over random batches
        for (int b = 0; b < 40; b++) begin
            logic [NCH-1:0] h, f;
            int n;
            h = '0;
            f = '0;
            n = 1 + ($urandom % 6);
            for (int k = 0; k < n; k++) begin
                int c;
                c = $urandom % NCH;
                h[c] = 1'b1;
                if ($urandom % 2) f[c] = 1'b1;
            end
            repeat ($urandom % 5) @(negedge clk);
            run_batch(h, f, -1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd12345);
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule